// File: doc/BRIEF.md
# Snoopy Invalidate Coherence Controller

This block tracks coherence ownership for the second-level cache of one processor in a shared-bus multiprocessor. Every line has one of three states: invalid, shared (the processor may read it) or exclusive (the processor may read and write it). The block holds only these states. It does not store data and does not choose lines to replace. Each line index has one state entry, and the processor's line address selects the entry.

A processor access is captured when the block is idle. The block then spends one coherence-check cycle with its stall output high before the access can complete. A coherent write to a line that is not exclusive needs write ownership. To get it, the block raises an invalidate request on a dedicated control bus and waits there. When the bus grants the request, the line becomes exclusive. Other processors' memory-bus traffic is snooped on a separate input. The invalidates that other caches broadcast on the control bus arrive on their own input. A non-coherent write goes around the cache and leaves the line state alone.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, and cpu_stall, cpu_done and inv_req are low.
- R2: An access is accepted only when cpu_req is high while cpu_stall is low. The next cycle is a coherence-check cycle with cpu_stall high. If no ownership upgrade is needed, cpu_done is high in that same cycle and the block is idle after it.
- R3: A read (cpu_we=0) to an invalid line leaves it shared. A read to a shared or exclusive line leaves the state unchanged. cpu_nc has no effect on reads.
- R4: A coherent write to an exclusive line completes in the check cycle without raising inv_req, and the line stays exclusive.
- R5: A coherent write to a shared or invalid line keeps cpu_stall high and, from the cycle after the check cycle, raises inv_req. While waiting, inv_addr carries the line index and holds steady. The access completes (cpu_done) in the cycle inv_gnt is high, and the line is exclusive from the next cycle on.
- R6: A non-coherent write (cpu_we=1, cpu_nc=1) completes in the check cycle, never raises inv_req and leaves the line state unchanged.
- R7: A snooped memory-bus read (snp_we=0) of an exclusive line makes it shared. It has no effect on shared or invalid lines.
- R8: A snooped memory-bus write (snp_we=1) to a line makes it invalid.
- R9: A remote invalidate (rinv_valid) for a line makes it invalid. A pending upgrade still waits for its grant and then makes the line exclusive.
- R10: In the cycle inv_gnt completes an upgrade, that line becomes exclusive even if a snoop or remote invalidate for the same line arrives in the same cycle. In all other cycles, snoop and remote-invalidate effects are applied after the local update of that cycle.
- R11: cpu_req is ignored while cpu_stall is high.
- R12: line_state shows, combinationally, the state of the line selected by cpu_addr, encoded 0 = invalid, 1 = shared, 2 = exclusive. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Access is a write |
| cpu_nc | input | 1 | Write is non-coherent (bypasses the cache) |
| cpu_addr | input | IW | Line index of the access; also selects line_state |
| cpu_stall | output | 1 | Block busy; processor must wait |
| cpu_done | output | 1 | Captured access completes this cycle |
| line_state | output | 2 | State of the line at cpu_addr |
| snp_valid | input | 1 | Memory-bus transaction from another processor |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_addr | input | IW | Line index of the snooped transaction |
| inv_req | output | 1 | Invalidate request on the control bus |
| inv_addr | output | IW | Line index of the invalidate |
| inv_gnt | input | 1 | Control bus accepts this block's invalidate |
| rinv_valid | input | 1 | Invalidate broadcast by another cache |
| rinv_addr | input | IW | Line index of the remote invalidate |

## Verification
The hardest situation to reach is a remote invalidate, or a snoop, for the same line that arrives in exactly the cycle the control bus grants this block's own upgrade. To build it, the bench first makes a line shared. It then issues a coherent write and holds inv_gnt low for several cycles so the upgrade stays pending. During that wait it sends a remote invalidate without a grant, and afterwards it drives inv_gnt together with another remote invalidate and a snooped write for the same index. A long stretch of random traffic, confined to four line indices, then runs these collisions many more times. A behavioural model checks each one cycle by cycle.

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_nc,
  input  logic [IW-1:0] cpu_addr,
  output logic          cpu_stall,
  output logic          cpu_done,
  output logic [1:0]    line_state,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [IW-1:0] snp_addr,
  output logic          inv_req,
  output logic [IW-1:0] inv_addr,
  input  logic          inv_gnt,
  input  logic          rinv_valid,
  input  logic [IW-1:0] rinv_addr
);
  localparam int LINES = 1 << IW;
  localparam logic [1:0] S_INV = 2'd0, S_SHR = 2'd1, S_EXC = 2'd2;

  typedef enum logic [1:0] {P_IDLE, P_CHECK, P_UPG} phase_t;

  phase_t        ph;
  logic          r_we, r_nc;
  logic [IW-1:0] r_addr;
  logic [1:0]    st  [LINES];
  logic [1:0]    nxt [LINES];

  wire [1:0] cur      = st[r_addr];
  wire       need_upg = r_we && !r_nc && (cur != S_EXC);
  wire       won      = (ph == P_UPG) && inv_gnt;

  assign cpu_stall  = (ph != P_IDLE);
  assign inv_req    = (ph == P_UPG);
  assign inv_addr   = r_addr;
  assign cpu_done   = ((ph == P_CHECK) && !need_upg) || won;
  assign line_state = st[cpu_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      r_we   <= 1'b0;
      r_nc   <= 1'b0;
      r_addr <= '0;
    end else begin
      case (ph)
        P_IDLE: if (cpu_req) begin
          ph     <= P_CHECK;
          r_we   <= cpu_we;
          r_nc   <= cpu_nc;
          r_addr <= cpu_addr;
        end
        P_CHECK: ph <= need_upg ? P_UPG : P_IDLE;
        P_UPG:   if (inv_gnt) ph <= P_IDLE;
        default: ph <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      nxt[i] = st[i];
      if ((ph == P_CHECK) && !r_we && (r_addr == IW'(i)) && (st[i] == S_INV))
        nxt[i] = S_SHR;
      if (won && (r_addr == IW'(i))) begin
        nxt[i] = S_EXC;
      end else begin
        if (snp_valid && (snp_addr == IW'(i))) begin
          if (snp_we) nxt[i] = S_INV;
          else if (nxt[i] == S_EXC) nxt[i] = S_SHR;
        end
        if (rinv_valid && (rinv_addr == IW'(i)))
          nxt[i] = S_INV;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= S_INV;
    end else begin
      st <= nxt;
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl_chk.sv
module snoop_coh_ctrl_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_addr_dummy,
  input logic [IW-1:0] cpu_addr,
  input logic          cpu_stall,
  input logic          cpu_done,
  input logic [1:0]    line_state,
  input logic          inv_req,
  input logic [IW-1:0] inv_addr,
  input logic          inv_gnt
);
  assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_stall);

  assert_accept_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |=> cpu_stall);

  assert_inv_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_gnt) |=> (inv_req && $stable(inv_addr)));

  assert_inv_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_gnt) |=> !inv_req);

  assert_no_early_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_gnt) |-> !cpu_done);

  assert_grant_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_gnt) |=> ((cpu_addr != $past(inv_addr)) || (line_state == 2'd2)));

  assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && !cpu_done) |=> cpu_stall);

  assert_legal_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    line_state != 2'b11);
endmodule

bind snoop_coh_ctrl snoop_coh_ctrl_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr_dummy(1'b0),
  .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
  .line_state(line_state), .inv_req(inv_req), .inv_addr(inv_addr),
  .inv_gnt(inv_gnt)
);

// File: tb/snoop_coh_ctrl_test.sv
module snoop_coh_ctrl_test;
  localparam int IW = 4;
  localparam int LINES = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_nc = 0;
  logic [IW-1:0] cpu_addr = '0, snp_addr = '0, rinv_addr = '0;
  logic snp_valid = 0, snp_we = 0, inv_gnt = 0, rinv_valid = 0;
  logic cpu_stall, cpu_done, inv_req;
  logic [1:0] line_state;
  logic [IW-1:0] inv_addr;

  always #10 clk = ~clk;

  snoop_coh_ctrl #(.IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_nc(cpu_nc),
    .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .line_state(line_state), .snp_valid(snp_valid), .snp_we(snp_we),
    .snp_addr(snp_addr), .inv_req(inv_req), .inv_addr(inv_addr),
    .inv_gnt(inv_gnt), .rinv_valid(rinv_valid), .rinv_addr(rinv_addr)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int mph = 0;
  bit mwe = 0, mnc = 0;
  int maddr = 0;
  int mst [LINES];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit req, input bit we, input bit nc, input int a,
                      input bit sv, input bit sw, input int sa, input bit g, input bit rv, input int ra);
    bit e_done, won;
    int waddr;
    @(negedge clk);
    cpu_req = req; cpu_we = we; cpu_nc = nc; cpu_addr = IW'(a);
    snp_valid = sv; snp_we = sw; snp_addr = IW'(sa);
    inv_gnt = g; rinv_valid = rv; rinv_addr = IW'(ra);
    #2;
    e_done = (mph == 1 && !(mwe && !mnc && mst[maddr] != 2)) || (mph == 2 && g);
    chk("R2", "cpu_stall", int'(cpu_stall), int'(mph != 0));
    chk("R2", "cpu_done", int'(cpu_done), int'(e_done));
    chk("R5", "inv_req", int'(inv_req), int'(mph == 2));
    if (mph == 2) chk("R5", "inv_addr", int'(inv_addr), maddr);
    chk(tag, "line_state", int'(line_state), mst[a]);
    @(posedge clk);
    won = (mph == 2) && g;
    waddr = maddr;
    if (mph == 1) begin
      if (mwe && !mnc && mst[maddr] != 2) mph = 2;
      else begin
        if (!mwe && mst[maddr] == 0) mst[maddr] = 1;
        mph = 0;
      end
    end else if (mph == 2) begin
      if (g) begin mst[maddr] = 2; mph = 0; end
    end else if (req) begin
      mwe = we; mnc = nc; maddr = a; mph = 1;
    end
    if (sv && !(won && sa == waddr)) begin
      if (sw) mst[sa] = 0;
      else if (mst[sa] == 2) mst[sa] = 1;
    end
    if (rv && !(won && ra == waddr)) mst[ra] = 0;
  endtask

  task automatic idle(input string tag, input int a);
    step(tag, 0, 0, 0, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic access(input string tag, input bit we, input bit nc, input int a);
    step(tag, 1, we, nc, a, 0, 0, 0, 0, 0, 0);
    idle(tag, a);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mst[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < LINES; i++) idle("R1", i);

    access("R3", 0, 0, 3);
    idle("R3", 3);
    access("R3", 0, 1, 3);
    idle("R3", 3);

    step("R5", 1, 1, 0, 3, 0, 0, 0, 0, 0, 0);
    idle("R5", 3);
    idle("R5", 3);
    step("R5", 0, 0, 0, 3, 0, 0, 0, 1, 0, 0);
    idle("R5", 3);

    access("R4", 1, 0, 3);
    idle("R4", 3);

    step("R7", 0, 0, 0, 3, 1, 0, 3, 0, 0, 0);
    idle("R7", 3);
    step("R7", 0, 0, 0, 3, 1, 0, 3, 0, 0, 0);
    idle("R7", 3);

    step("R5", 1, 1, 0, 5, 0, 0, 0, 0, 0, 0);
    idle("R5", 5);
    step("R5", 0, 0, 0, 5, 0, 0, 0, 1, 0, 0);
    idle("R5", 5);
    step("R8", 0, 0, 0, 5, 1, 1, 5, 0, 0, 0);
    idle("R8", 5);

    access("R9", 0, 0, 6);
    step("R9", 0, 0, 0, 6, 0, 0, 0, 0, 1, 6);
    idle("R9", 6);

    access("R6", 1, 1, 7);
    idle("R6", 7);
    access("R6", 0, 0, 8);
    access("R6", 1, 1, 8);
    idle("R6", 8);

    access("R10", 0, 0, 9);
    step("R10", 1, 1, 0, 9, 0, 0, 0, 0, 0, 0);
    idle("R10", 9);
    step("R9", 0, 0, 0, 9, 0, 0, 0, 0, 1, 9);
    idle("R9", 9);
    step("R10", 0, 0, 0, 9, 1, 1, 9, 1, 1, 9);
    idle("R10", 9);
    step("R10", 0, 0, 0, 9, 1, 1, 9, 0, 0, 0);
    idle("R10", 9);

    step("R11", 1, 0, 0, 10, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 0, 0, 11, 0, 0, 0, 0, 0, 0);
    idle("R11", 11);
    idle("R11", 10);

    for (int n = 0; n < 4000; n++) begin
      step("R12", ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
           int'($urandom % 4), ($urandom % 4) == 0, ($urandom % 2) == 0,
           int'($urandom % 4), ($urandom % 3) == 0, ($urandom % 6) == 0,
           int'($urandom % 4));
    end
    for (int i = 0; i < 4; i++) idle("R12", i);

    finished = 1;
    finish_up();
  end
endmodule